// File: doc/BRIEF.md
# Pattern Serializer for Multi-Pin Output

The block turns a stream of 32-bit words into samples that drive one, two or four output pins. Software starts a transfer with a length in whole words, an output mode and an event enable. A memory-side requester then keeps two 16-word internal banks full. Each pulse of the sample strobe moves the pins on by one sample. A word is unpacked from its least significant end, and the next word is fetched from the active bank when the current one is used up. The two banks alternate: while one feeds the pins, the other can be refilled.

When the final word of the transfer reaches the pins, the block can raise a fixed-length event pulse, so that software or another block can timestamp the end of the pattern. If the strobe needs a word and the active bank has not been filled yet, the block holds its pins and sets a sticky overrun flag. It does not drop the sample. It resumes once the bank arrives.

Top module: `pattern_serializer`

## Requirements
- R1: The mode is encoded as follows: 2'b00 drives one pin and gives 32 samples per word, 2'b01 drives two pins and gives 16 samples, and 2'b10 or 2'b11 drives four pins and gives 8 samples. busy_o stays high until the strobe after the last sample of the last word.
- R2: Samples leave a word starting at bit 0. Bit k of a sample drives pins_o[k], and pins the mode does not drive read 0.
- R3: After start_i, the first strobe loads the first word and presents its sample 0. Later strobes shift to the next sample, and the strobe after the last sample of a word loads the next word.
- R4: A transfer ends after word_count_i words. The strobe after the last sample clears busy_o while pins_o keeps its value. A start with a count of zero leaves busy_o low, and busy_o is low after reset.
- R5: Words are read from bank 0 at addresses 0 to 15, then from bank 1, alternating. A bank is released, and its refill request raised, in the cycle its 16th word is loaded.
- R6: refill_req_o[b] is high while busy_o is high and bank b is not marked filled. A pulse on fill_done_i[b] marks bank b filled, and start_i clears both marks.
- R7: If the event enable was set at start, last_ev_o rises in the same cycle that pins_o first shows the last word. It stays low for earlier words and for transfers started with the enable clear.
- R8: The event pulse lasts exactly PULSE_CYC clock cycles.
- R9: A strobe that needs a word while the active bank is not filled sets overrun_o, leaves pins_o unchanged and consumes no word. The flag stays set until ovr_clr_i.
- R10: The mode and the event enable are captured at start_i. Changing mode_i or ev_en_i during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a transfer; captures count, mode and event enable |
| word_count_i | input | CNT_W | Transfer length in 32-bit words |
| mode_i | input | 2 | Pin-count mode (see R1) |
| ev_en_i | input | 1 | Enable the last-word event for this transfer |
| strobe_i | input | 1 | Advance output by one sample |
| fill_we_i | input | 1 | Write strobe of the refill port |
| fill_buf_i | input | 1 | Bank selected for the refill write |
| fill_addr_i | input | $clog2(DEPTH) | Word address inside the bank |
| fill_data_i | input | DW | Refill data word |
| fill_done_i | input | 2 | One bit per bank: the bank is now filled |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| pins_o | output | 4 | Output pins |
| refill_req_o | output | 2 | One bit per bank: the bank wants data |
| last_ev_o | output | 1 | Last-word event pulse |
| overrun_o | output | 1 | Sticky overrun flag |
| busy_o | output | 1 | Transfer in progress |

## Verification
A wrong sample index or shift amount shows on pins_o at the very next strobe, as a bit pattern that differs from the expected slice of the word. A wrong bank pointer or wrong bank flags show when a word boundary is crossed: the pins carry data from the wrong bank, or refill_req_o fails to move in the cycle the 16th word loads. A miscounted word total shows as busy_o dropping one word early or late. A miscounted pulse counter shows within PULSE_CYC cycles of the last word loading.

// File: rtl/pgs_pkg.sv
// Package for the pattern serializer.
// Holds the bank count, the pin count and the mode decode shared by all modules.
package pgs_pkg;

    localparam int unsigned PG_BANKS = 2;
    localparam int unsigned PG_LANES = 4;

    typedef enum logic [1:0] {
        MODE_1PIN   = 2'b00,
        MODE_2PIN   = 2'b01,
        MODE_4PIN   = 2'b10,
        MODE_4PIN_B = 2'b11
    } pg_mode_e;

    // Number of pins driven, which is also the bits per sample, for a mode code.
    function automatic logic [2:0] lane_width(input logic [1:0] mode);
        case (pg_mode_e'(mode))
            MODE_1PIN: return 3'd1;
            MODE_2PIN: return 3'd2;
            default:   return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pgs_pingpong.sv
// Two-bank word store with per-bank filled flags.
// The writer fills a bank through the write port and then pulses done for that bank.
// The reader releases a bank after it has read the bank's last word.
// Assumes the writer touches only banks that are not marked filled.
module pgs_pingpong
    import pgs_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      we_i,
    input  logic                      wbuf_i,
    input  logic [$clog2(DEPTH)-1:0]  waddr_i,
    input  logic [DW-1:0]             wdata_i,
    input  logic [PG_BANKS-1:0]       done_i,
    input  logic                      rel_i,
    input  logic                      rel_buf_i,
    input  logic                      rd_buf_i,
    input  logic [$clog2(DEPTH)-1:0]  raddr_i,
    output logic [DW-1:0]             rdata_o,
    output logic [PG_BANKS-1:0]       full_o
);

    logic [DW-1:0] bank_q [PG_BANKS];

    for (genvar b = 0; b < PG_BANKS; b++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];
        logic          full_r;

        // Store a refill word into this bank.
        always_ff @(posedge clk) begin
            if (we_i && (wbuf_i == 1'(b))) begin
                mem[waddr_i] <= wdata_i;
            end
        end

        // Track whether this bank holds unread data.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_r <= 1'b0;
            end else if (clr_i) begin
                full_r <= 1'b0;
            end else if (done_i[b]) begin
                full_r <= 1'b1;
            end else if (rel_i && (rel_buf_i == 1'(b))) begin
                full_r <= 1'b0;
            end
        end

        assign full_o[b] = full_r;
        assign bank_q[b] = mem[raddr_i];
    end

    assign rdata_o = bank_q[rd_buf_i];

    // R5
    release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |-> full_o[rel_buf_i]);

endmodule

// File: rtl/pgs_unpack.sv
// Word unpacker.
// Holds the current word and shifts one sample out per advance, lowest bits first.
// Reports when the last sample of the word is on the pins.
// Assumes the mode input is stable except in the cycle of a clear.
module pgs_unpack
    import pgs_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 load_i,
    input  logic [DW-1:0]        word_i,
    input  logic                 adv_i,
    input  logic [1:0]           mode_i,
    output logic [PG_LANES-1:0]  pins_o,
    output logic                 has_word_o,
    output logic                 last_samp_o
);

    localparam int unsigned IW = $clog2(DW);
    localparam int unsigned SW = IW + 1;

    logic [DW-1:0] shreg;
    logic [IW-1:0] idx;
    logic          has_q;
    logic [2:0]    width;
    logic [SW-1:0] spw;

    assign width = lane_width(mode_i);

    // Samples per word for the current mode.
    always_comb begin
        case (width)
            3'd1:    spw = SW'(DW);
            3'd2:    spw = SW'(DW / 2);
            default: spw = SW'(DW / 4);
        endcase
    end

    assign last_samp_o = ({1'b0, idx} == (spw - SW'(1)));
    assign has_word_o  = has_q;

    // Load a new word or shift to its next sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            has_q <= 1'b0;
        end else if (clr_i) begin
            idx   <= '0;
            has_q <= 1'b0;
        end else if (load_i) begin
            shreg <= word_i;
            idx   <= '0;
            has_q <= 1'b1;
        end else if (adv_i) begin
            shreg <= shreg >> width;
            idx   <= idx + 1'b1;
        end
    end

    for (genvar k = 0; k < PG_LANES; k++) begin : g_lane
        assign pins_o[k] = (int'(width) > k) ? shreg[k] : 1'b0;
    end

    // R1
    samp_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        has_q |-> ({1'b0, idx} < spw));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (has_word_o && (idx == '0)));

endmodule

// File: rtl/pgs_evpulse.sv
// Fixed-length event pulse.
// A trigger loads a down-counter, and the output is high while the counter is non-zero.
// Assumes PULSE_CYC is at least 1. A new trigger restarts the pulse.
module pgs_evpulse #(
    parameter int unsigned PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic ev_o
);

    localparam int unsigned CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] cnt;

    // Count down the remaining pulse cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (trig_i) begin
            cnt <= CW'(PULSE_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign ev_o = (cnt != '0);

    // R7
    ev_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_o) |-> $past(trig_i));

    // R8
    ev_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> ev_o);

endmodule

// File: rtl/pattern_serializer.sv
// Pattern serializer top.
// Counts the words of a transfer, walks the two banks in turn and feeds the unpacker.
// Raises the last-word event and the overrun flag.
// Assumes strobe_i is a single-cycle pulse and start_i is not given while the refill port is writing.
module pattern_serializer
    import pgs_pkg::*;
#(
    parameter int unsigned DW        = 32,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PULSE_CYC = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [CNT_W-1:0]          word_count_i,
    input  logic [1:0]                mode_i,
    input  logic                      ev_en_i,
    input  logic                      strobe_i,
    input  logic                      fill_we_i,
    input  logic                      fill_buf_i,
    input  logic [$clog2(DEPTH)-1:0]  fill_addr_i,
    input  logic [DW-1:0]             fill_data_i,
    input  logic [PG_BANKS-1:0]       fill_done_i,
    input  logic                      ovr_clr_i,
    output logic [PG_LANES-1:0]       pins_o,
    output logic [PG_BANKS-1:0]       refill_req_o,
    output logic                      last_ev_o,
    output logic                      overrun_o,
    output logic                      busy_o
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

    logic              running;
    logic [CNT_W-1:0]  remain;
    logic              act;
    logic [AW-1:0]     rd_ptr;
    logic [1:0]        mode_q;
    logic              ev_en_q;
    logic              ovr_q;

    logic [DW-1:0]       rd_word;
    logic [PG_BANKS-1:0] full;
    logic                has_word;
    logic                last_samp;
    logic                go, need, adv, words_left, load, starve, finish, rel, trig;

    // Decide what this strobe does: shift, load, stall or end.
    always_comb begin
        go         = strobe_i & running & ~start_i;
        need       = go & (~has_word | last_samp);
        adv        = go & has_word & ~last_samp;
        words_left = (remain != '0);
        load       = need & words_left & full[act];
        starve     = need & words_left & ~full[act];
        finish     = need & ~words_left;
        rel        = load & (rd_ptr == PTR_LAST);
        trig       = load & ev_en_q & (remain == ONE_LEFT);
    end

    // Transfer state: word counter, bank pointer and captured settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            remain  <= '0;
            act     <= 1'b0;
            rd_ptr  <= '0;
            mode_q  <= 2'b00;
            ev_en_q <= 1'b0;
        end else if (start_i) begin
            running <= (word_count_i != '0);
            remain  <= word_count_i;
            act     <= 1'b0;
            rd_ptr  <= '0;
            mode_q  <= mode_i;
            ev_en_q <= ev_en_i;
        end else begin
            if (load) begin
                remain <= remain - 1'b1;
                rd_ptr <= rel ? '0 : rd_ptr + 1'b1;
                if (rel) begin
                    act <= ~act;
                end
            end
            if (finish) begin
                running <= 1'b0;
            end
        end
    end

    // Sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (starve) begin
            ovr_q <= 1'b1;
        end else if (ovr_clr_i) begin
            ovr_q <= 1'b0;
        end
    end

    pgs_pingpong #(.DW(DW), .DEPTH(DEPTH)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (start_i),
        .we_i      (fill_we_i),
        .wbuf_i    (fill_buf_i),
        .waddr_i   (fill_addr_i),
        .wdata_i   (fill_data_i),
        .done_i    (fill_done_i),
        .rel_i     (rel),
        .rel_buf_i (act),
        .rd_buf_i  (act),
        .raddr_i   (rd_ptr),
        .rdata_o   (rd_word),
        .full_o    (full)
    );

    pgs_unpack #(.DW(DW)) u_unpack (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (start_i),
        .load_i      (load),
        .word_i      (rd_word),
        .adv_i       (adv),
        .mode_i      (mode_q),
        .pins_o      (pins_o),
        .has_word_o  (has_word),
        .last_samp_o (last_samp)
    );

    pgs_evpulse #(.PULSE_CYC(PULSE_CYC)) u_event (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig),
        .ev_o   (last_ev_o)
    );

    assign refill_req_o = {PG_BANKS{running}} & ~full;
    assign overrun_o    = ovr_q;
    assign busy_o       = running;

    // R9
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $stable(pins_o));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !ovr_clr_i) |=> overrun_o);

    // R2
    lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b00) |-> (pins_o[PG_LANES-1:1] == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(pins_o));

    // R4
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(strobe_i) || $past(start_i)));

endmodule

// File: tb/pattern_serializer_tb.sv
module pattern_serializer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int DEPTH      = 16;
    localparam int CNT_W      = 16;
    localparam int PULSE_CYC  = 8;

    // Each entry holds {mode, word}; the bench derives the expected samples.
    localparam logic [33:0] VECS [6] = '{
        {2'b00, 32'h8000_0001},
        {2'b00, 32'h5555_AAAA},
        {2'b01, 32'hE4E4_1B1B},
        {2'b01, 32'h0F0F_F0F0},
        {2'b10, 32'h7654_3210},
        {2'b11, 32'hFEDC_BA98}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic [CNT_W-1:0] word_count_i;
    logic [1:0]       mode_i;
    logic             ev_en_i;
    logic             strobe_i;
    logic             fill_we_i;
    logic             fill_buf_i;
    logic [3:0]       fill_addr_i;
    logic [DW-1:0]    fill_data_i;
    logic [1:0]       fill_done_i;
    logic             ovr_clr_i;
    logic [3:0]       pins_o;
    logic [1:0]       refill_req_o;
    logic             last_ev_o;
    logic             overrun_o;
    logic             busy_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  reported = 1'b0;
    logic [3:0] hold;
    int  hi;
    int  evseen;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pattern_serializer #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .word_count_i (word_count_i),
        .mode_i       (mode_i),
        .ev_en_i      (ev_en_i),
        .strobe_i     (strobe_i),
        .fill_we_i    (fill_we_i),
        .fill_buf_i   (fill_buf_i),
        .fill_addr_i  (fill_addr_i),
        .fill_data_i  (fill_data_i),
        .fill_done_i  (fill_done_i),
        .ovr_clr_i    (ovr_clr_i),
        .pins_o       (pins_o),
        .refill_req_o (refill_req_o),
        .last_ev_o    (last_ev_o),
        .overrun_o    (overrun_o),
        .busy_o       (busy_o)
    );

    function automatic logic [31:0] pat(input int n);
        return (32'h9E37_79B9 * 32'(n + 1)) ^ 32'(n << 16);
    endfunction

    function automatic int lw(input logic [1:0] m);
        return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
    endfunction

    function automatic int spw(input logic [1:0] m);
        return 32 / lw(m);
    endfunction

    function automatic logic [31:0] exp_pins(input logic [1:0] m, input logic [31:0] w, input int s);
        logic [31:0] sh;
        sh = w >> (s * lw(m));
        return sh & ((32'd1 << lw(m)) - 32'd1);
    endfunction

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic start_xfer(input int count, input logic [1:0] m, input logic ev);
        start_i      = 1'b1;
        word_count_i = CNT_W'(count);
        mode_i       = m;
        ev_en_i      = ev;
        cyc();
        start_i = 1'b0;
        mode_i  = ~m;
        ev_en_i = ~ev;
    endtask

    task automatic write_word(input logic b, input int a, input logic [31:0] d);
        fill_we_i   = 1'b1;
        fill_buf_i  = b;
        fill_addr_i = 4'(a);
        fill_data_i = d;
        cyc();
        fill_we_i = 1'b0;
    endtask

    task automatic mark_done(input logic b);
        fill_done_i[b] = 1'b1;
        cyc();
        fill_done_i = 2'b00;
    endtask

    task automatic fill_bank(input logic b, input int base);
        for (int i = 0; i < DEPTH; i++) begin
            write_word(b, i, pat(base + i));
        end
        mark_done(b);
    endtask

    task automatic strobe();
        strobe_i = 1'b1;
        cyc();
        strobe_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; word_count_i = '0; mode_i = 2'b00; ev_en_i = 1'b0;
        strobe_i = 1'b0; fill_we_i = 1'b0; fill_buf_i = 1'b0; fill_addr_i = '0;
        fill_data_i = '0; fill_done_i = 2'b00; ovr_clr_i = 1'b0;
        @(negedge clk);
        cyc(); cyc(); cyc();
        rst_n = 1'b1;
        cyc();

        // Reset state
        check("R4 reset busy", 32'(busy_o), 0);
        check("R2 reset pins", 32'(pins_o), 0);
        check("R6 reset requests", 32'(refill_req_o), 0);
        check("R7 reset event", 32'(last_ev_o), 0);
        check("R9 reset overrun", 32'(overrun_o), 0);

        // Single-word transfers across the modes, one per table row
        for (int v = 0; v < 6; v++) begin
            logic [1:0]  m;
            logic [31:0] w;
            m = VECS[v][33:32];
            w = VECS[v][31:0];
            start_xfer(1, m, 1'b1);
            check("R6 start requests both banks", 32'(refill_req_o), 2'b11);
            write_word(1'b0, 0, w);
            mark_done(1'b0);
            check("R6 bank0 filled", 32'(refill_req_o), 2'b10);
            check("R7 no stale event", 32'(last_ev_o), 0);
            for (int s = 0; s < spw(m); s++) begin
                strobe();
                check("R2 R10 sample value", 32'(pins_o), exp_pins(m, w, s));
                if (s == 0) check("R7 event with last word", 32'(last_ev_o), 1);
            end
            check("R1 busy through all samples", 32'(busy_o), 1);
            strobe();
            check("R4 busy clears at end", 32'(busy_o), 0);
            check("R4 pins hold at end", 32'(pins_o), exp_pins(m, w, spw(m) - 1));
        end

        // Two banks, 18 words in four-pin mode
        start_xfer(18, 2'b10, 1'b1);
        fill_bank(1'b0, 0);
        check("R6 one bank filled", 32'(refill_req_o), 2'b10);
        fill_bank(1'b1, 16);
        check("R6 both banks filled", 32'(refill_req_o), 2'b00);
        for (int wi = 0; wi < 18; wi++) begin
            for (int s = 0; s < 8; s++) begin
                strobe();
                check("R3 R5 word sample", 32'(pins_o), exp_pins(2'b10, pat(wi), s));
                if (s == 0 && wi == 15) check("R5 bank0 released", 32'(refill_req_o), 2'b01);
                if (s == 0 && wi == 16) check("R7 no event before last word", 32'(last_ev_o), 0);
                if (s == 0 && wi == 17) begin
                    check("R7 event on last word", 32'(last_ev_o), 1);
                    hi = 0;
                    while (last_ev_o && hi < 100) begin
                        hi++;
                        cyc();
                    end
                    check("R8 pulse length", 32'(hi), 32'(PULSE_CYC));
                end
            end
        end
        strobe();
        check("R4 end after 18 words", 32'(busy_o), 0);
        check("R6 no request when idle", 32'(refill_req_o), 2'b00);

        // Overrun, recovery and clear; event disabled
        start_xfer(2, 2'b00, 1'b0);
        hold = pins_o;
        strobe();
        check("R9 overrun set", 32'(overrun_o), 1);
        check("R9 pins hold on overrun", 32'(pins_o), 32'(hold));
        check("R9 still busy", 32'(busy_o), 1);
        strobe();
        check("R9 overrun remains", 32'(overrun_o), 1);
        fill_bank(1'b0, 40);
        strobe();
        check("R9 no word lost", 32'(pins_o), exp_pins(2'b00, pat(40), 0));
        check("R9 flag sticky", 32'(overrun_o), 1);
        ovr_clr_i = 1'b1;
        cyc();
        ovr_clr_i = 1'b0;
        check("R9 flag cleared", 32'(overrun_o), 0);
        evseen = 0;
        for (int k = 1; k < 64; k++) begin
            strobe();
            if (last_ev_o) evseen++;
            if (k == 32) check("R3 second word", 32'(pins_o), exp_pins(2'b00, pat(41), 0));
        end
        check("R9 word count intact", 32'(busy_o), 1);
        check("R7 event disabled", 32'(evseen), 0);
        strobe();
        check("R4 ends after two words", 32'(busy_o), 0);

        // Zero-length transfer
        start_xfer(0, 2'b01, 1'b1);
        check("R4 zero count idle", 32'(busy_o), 0);
        check("R6 zero count no request", 32'(refill_req_o), 2'b00);

        summary();
        $finish;
    end

endmodule